// File: doc/BRIEF.md
# Aliased Multi-Width Register File

This block holds eight 32-bit general-purpose registers that can each be reached at three widths over the same storage. A full access covers all 32 bits. A half access covers bits 15:0. A byte access covers either bits 7:0 or bits 15:8, and byte views exist only for registers 0 to 3. Registers are numbered 0 to 7 in this order: accumulator, count, data, base, stack pointer, frame pointer, source index and destination index. The file has two combinational read ports and one write port. Every port carries a 3-bit register index and a 2-bit size code. Read data is always zero-extended to 32 bits.

A narrow write merges into the wider physical register and leaves every bit outside its lane unchanged. Read port A doubles as the source operand of the operation that drives the write port. If the write size and the port-A size differ, the write is refused and an error is flagged in the same cycle. The block has no control state machine. Its only state is the register storage, which is cleared by a synchronous reset and updated on the rising clock edge.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous reset, sampled high on a rising edge, clears all eight registers to zero.
- R2: Size code 2'b10 (word) reads and writes all 32 bits of register `idx`. A write becomes visible on the read ports after the rising edge that has `wr_en` high.
- R3: Size code 2'b01 (half) writes only bits 15:0 of register `idx`. Bits 31:16 keep their previous value.
- R4: Size code 2'b00 (byte) with index 0 to 3 writes only bits 7:0 of register `idx`. All other bits are kept.
- R5: Size code 2'b00 with index 4 to 7 writes only bits 15:8 of register `idx-4`. All other bits are kept.
- R6: A byte read returns the selected lane in bits 7:0, with the same index mapping as R4 and R5. A half read returns bits 15:0. Both views place zeros in every higher bit.
- R7: When `wr_en` is high and `wr_size` differs from `rd_a_size`, `wr_err` is high in that cycle and no register changes.
- R8: Size code 2'b11 is reserved. A write with this size raises `wr_err` and changes nothing. A read with this size returns zero.
- R9: Reads have no write-through path. A read of the register being written in the same cycle returns the value it held before the edge.
- R10: The two read ports are independent. Copying a register to another through port B and the write port leaves the source unchanged.
- R11: With `wr_en` low, no register changes and `wr_err` stays low, whatever the other write inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 3 | Read port A register or byte-view index |
| rd_a_size | input | 2 | Read port A size code; also the source width checked against the write |
| rd_a_data | output | 32 | Read port A data, zero-extended |
| rd_b_idx | input | 3 | Read port B register or byte-view index |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 32 | Read port B data, zero-extended |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register or byte-view index |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data; narrow writes use the low bits |
| wr_err | output | 1 | Width mismatch or reserved size on a requested write |

## Verification
Because reads are combinational, a bad merge or a wrong lane select shows on a read port one edge after the faulty write, as long as the same register is read back at every width. A corrupted upper half or a neighbouring byte stays hidden until that lane is read. For this reason every narrow write is followed by a full-word read that exposes the bits which should have been kept. An error that fails to block a write shows as a changed word on the next cycle, and a missing bypass guard shows as the new value appearing before the edge.

// File: rtl/arf_pkg.sv
package arf_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/arf_read_view.sv
module arf_read_view
    import arf_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int DATA_W = 32,
    parameter int IDXW   = 3
) (
    input  logic [DATA_W-1:0] regs [NREG],
    input  logic [IDXW-1:0]   idx,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] data
);
    localparam int HALF_W = DATA_W / 2;

    logic [IDXW-1:0]   phys;
    logic              hi_sel;
    logic [DATA_W-1:0] word;

    // byte views fold the top index bit into a lane select
    always_comb begin
        phys   = idx;
        hi_sel = idx[IDXW-1];
        if (size_e'(size) == SZ_BYTE) phys[IDXW-1] = 1'b0;
    end

    assign word = regs[phys];

    always_comb begin
        data = '0;
        unique case (size_e'(size))
            SZ_BYTE: data[BYTE_W-1:0] = hi_sel ? word[2*BYTE_W-1:BYTE_W] : word[BYTE_W-1:0];
            SZ_HALF: data[HALF_W-1:0] = word[HALF_W-1:0];
            SZ_WORD: data = word;
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/arf_write_merge.sv
module arf_write_merge
    import arf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        size,
    input  logic              hi_sel,
    output logic [DATA_W-1:0] merged
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        merged = old_word;
        unique case (size_e'(size))
            SZ_BYTE: begin
                if (hi_sel) merged[2*BYTE_W-1:BYTE_W] = wdata[BYTE_W-1:0];
                else        merged[BYTE_W-1:0]        = wdata[BYTE_W-1:0];
            end
            SZ_HALF: merged[HALF_W-1:0] = wdata[HALF_W-1:0];
            SZ_WORD: merged = wdata;
            default: merged = old_word;
        endcase
    end
endmodule

// File: rtl/arf_width_check.sv
module arf_width_check
    import arf_pkg::*;
(
    input  logic       wr_en,
    input  logic [1:0] wr_size,
    input  logic [1:0] src_size,
    output logic       err
);
    logic mismatch;
    logic reserved;

    assign mismatch = (wr_size != src_size);
    assign reserved = (size_e'(wr_size) == SZ_RSVD);
    assign err      = wr_en && (mismatch || reserved);
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
    import arf_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NREG)-1:0] rd_a_idx,
    input  logic [1:0]              rd_a_size,
    output logic [DATA_W-1:0]       rd_a_data,
    input  logic [$clog2(NREG)-1:0] rd_b_idx,
    input  logic [1:0]              rd_b_size,
    output logic [DATA_W-1:0]       rd_b_data,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [1:0]              wr_size,
    input  logic [DATA_W-1:0]       wr_data,
    output logic                    wr_err
);
    localparam int IDXW   = $clog2(NREG);
    localparam int NPORTS = 2;

    logic [DATA_W-1:0]      regs_q [NREG];
    logic [NREG*DATA_W-1:0] store_flat;
    logic [IDXW-1:0]        wr_tgt;
    logic [DATA_W-1:0]      wr_merged;
    logic                   wr_go;

    logic [IDXW-1:0]   rd_idx_v  [NPORTS];
    logic [1:0]        rd_size_v [NPORTS];
    logic [DATA_W-1:0] rd_data_v [NPORTS];

    arf_width_check u_check (
        .wr_en    (wr_en),
        .wr_size  (wr_size),
        .src_size (rd_a_size),
        .err      (wr_err)
    );

    assign wr_go = wr_en && !wr_err;

    always_comb begin
        wr_tgt = wr_idx;
        if (size_e'(wr_size) == SZ_BYTE) wr_tgt[IDXW-1] = 1'b0;
    end

    arf_write_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word (regs_q[wr_tgt]),
        .wdata    (wr_data),
        .size     (wr_size),
        .hi_sel   (wr_idx[IDXW-1]),
        .merged   (wr_merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (wr_go) begin
            regs_q[wr_tgt] <= wr_merged;
        end
    end

    assign rd_idx_v[0]  = rd_a_idx;
    assign rd_size_v[0] = rd_a_size;
    assign rd_idx_v[1]  = rd_b_idx;
    assign rd_size_v[1] = rd_b_size;

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        arf_read_view #(.NREG(NREG), .DATA_W(DATA_W), .IDXW(IDXW)) u_view (
            .regs (regs_q),
            .idx  (rd_idx_v[p]),
            .size (rd_size_v[p]),
            .data (rd_data_v[p])
        );
    end

    assign rd_a_data = rd_data_v[0];
    assign rd_b_data = rd_data_v[1];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign store_flat[g*DATA_W +: DATA_W] = regs_q[g];
    end
endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk
    import arf_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int DATA_W = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [1:0]             wr_size,
    input logic                   wr_err,
    input logic [1:0]             rd_a_size,
    input logic [DATA_W-1:0]      rd_a_data,
    input logic [1:0]             rd_b_size,
    input logic [DATA_W-1:0]      rd_b_data,
    input logic [NREG*DATA_W-1:0] store
);
    localparam int HALF_W = DATA_W / 2;

    logic [NREG*HALF_W-1:0] upper;
    logic                   prev_rst;

    for (genvar g = 0; g < NREG; g++) begin : g_up
        assign upper[g*HALF_W +: HALF_W] = store[g*DATA_W+HALF_W +: HALF_W];
    end

    always_ff @(posedge clk) begin
        prev_rst <= rst;
        if (prev_rst) begin
            p_reset_clear_r1: assert (store == '0) else $error("R1 storage not cleared");
        end
    end

    p_upper_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_size == SZ_BYTE || wr_size == SZ_HALF)) |=> $stable(upper));

    p_byte_zext_a_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_a_size == SZ_BYTE) |-> (rd_a_data[DATA_W-1:BYTE_W] == '0));

    p_half_zext_b_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_b_size == SZ_HALF) |-> (rd_b_data[DATA_W-1:HALF_W] == '0));

    p_err_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> $stable(store));

    p_rsvd_err_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == SZ_RSVD) |-> wr_err);

    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_b_size == SZ_RSVD) |-> (rd_b_data == '0));

    p_idle_noerr_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !wr_err);

    p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(store));
endmodule

bind alias_regfile alias_regfile_chk #(.NREG(NREG), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_size   (wr_size),
    .wr_err    (wr_err),
    .rd_a_size (rd_a_size),
    .rd_a_data (rd_a_data),
    .rd_b_size (rd_b_size),
    .rd_b_data (rd_b_data),
    .store     (store_flat)
);

// File: tb/tb_alias_regfile.sv
`timescale 1ns/100ps
module tb_alias_regfile;
    localparam logic [1:0] SB = 2'b00, SH = 2'b01, SW = 2'b10, SR = 2'b11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [1:0]  rd_a_size = SW, rd_b_size = SW, wr_size = SW;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0;
    logic        wr_err;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m [8];

    always #2.5 clk = ~clk;

    alias_regfile dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
        .wr_err(wr_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_b(input string tag, input logic [2:0] idx, input logic [1:0] sz,
                        input logic [31:0] exp);
        rd_b_idx = idx; rd_b_size = sz;
        #1;
        check(tag, rd_b_data, exp);
    endtask

    task automatic do_wr(input logic [2:0] idx, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_size = sz; wr_data = d;
        rd_a_idx = idx; rd_a_size = sz;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rd_b(i == 0 ? "R1 reset reg0" : "R1 reset", 3'(i), SW, 32'h0);
        end
    endtask

    task automatic t_word;
        for (int i = 0; i < 8; i++) begin
            m[i] = {8'hA0 + 8'(i), 8'h5B, 8'h3C + 8'(i), 8'h7D};
            do_wr(3'(i), SW, m[i]);
        end
        for (int i = 0; i < 8; i++) rd_b("R2 word readback", 3'(i), SW, m[i]);
        rd_a_idx = 3'd5; rd_a_size = SW; #1;
        check("R2 word port A", rd_a_data, m[5]);
    endtask

    task automatic t_half;
        do_wr(3'd6, SH, 32'h1234_BEEF);
        m[6] = {m[6][31:16], 16'hBEEF};
        rd_b("R3 half write keeps upper", 3'd6, SW, m[6]);
    endtask

    task automatic t_low_byte;
        do_wr(3'd1, SB, 32'hFFFF_FF5A);
        m[1] = {m[1][31:8], 8'h5A};
        rd_b("R4 low byte merge", 3'd1, SW, m[1]);
    endtask

    task automatic t_high_byte;
        do_wr(3'd6, SB, 32'h0000_00C3);
        m[2] = {m[2][31:16], 8'hC3, m[2][7:0]};
        rd_b("R5 high byte merge reg2", 3'd2, SW, m[2]);
        rd_b("R5 reg6 untouched", 3'd6, SW, m[6]);
    endtask

    task automatic t_views;
        rd_b("R6 byte view low reg2", 3'd2, SB, {24'h0, m[2][7:0]});
        rd_b("R6 byte view high reg2", 3'd6, SB, {24'h0, m[2][15:8]});
        rd_b("R6 half view reg7", 3'd7, SH, {16'h0, m[7][15:0]});
        rd_b("R6 byte view high reg3", 3'd7, SB, {24'h0, m[3][15:8]});
    endtask

    task automatic t_mismatch;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd4; wr_size = SW; wr_data = 32'hDEAD_0000;
        rd_a_idx = 3'd0; rd_a_size = SH;
        #1;
        check("R7 mismatch flags error", {31'h0, wr_err}, 32'h1);
        @(negedge clk);
        wr_en = 1'b0;
        rd_b("R7 mismatch no write", 3'd4, SW, m[4]);
    endtask

    task automatic t_reserved;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd3; wr_size = SR; wr_data = 32'h0BAD_0BAD;
        rd_a_idx = 3'd3; rd_a_size = SR;
        #1;
        check("R8 reserved write error", {31'h0, wr_err}, 32'h1);
        @(negedge clk);
        wr_en = 1'b0;
        rd_b("R8 reserved no write", 3'd3, SW, m[3]);
        rd_b("R8 reserved read zero", 3'd3, SR, 32'h0);
    endtask

    task automatic t_no_bypass;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd0; wr_size = SW; wr_data = 32'hCAFE_F00D;
        rd_a_idx = 3'd0; rd_a_size = SW;
        #1;
        check("R9 same cycle old value", rd_a_data, m[0]);
        @(negedge clk);
        wr_en = 1'b0;
        m[0] = 32'hCAFE_F00D;
        #1;
        check("R9 new value after edge", rd_a_data, m[0]);
    endtask

    task automatic t_move;
        @(negedge clk);
        rd_b_idx = 3'd3; rd_b_size = SW;
        rd_a_idx = 3'd1; rd_a_size = SW;
        #1;
        check("R10 port A independent", rd_a_data, m[1]);
        wr_en = 1'b1; wr_idx = 3'd5; wr_size = SW; wr_data = rd_b_data;
        @(negedge clk);
        wr_en = 1'b0;
        m[5] = m[3];
        rd_b("R10 destination updated", 3'd5, SW, m[5]);
        rd_b("R10 source unchanged", 3'd3, SW, m[3]);
    endtask

    task automatic t_idle;
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 3'd7; wr_size = SR; wr_data = 32'h5555_AAAA;
        rd_a_size = SB;
        #1;
        check("R11 idle no error", {31'h0, wr_err}, 32'h0);
        @(negedge clk);
        rd_b("R11 idle no write", 3'd7, SW, m[7]);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word();
        t_half();
        t_low_byte();
        t_high_byte();
        t_views();
        t_mismatch();
        t_reserved();
        t_no_bypass();
        t_move();
        t_idle();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule